// File: doc/BRIEF.md
# Two-Channel Serial Audio Slave Receiver with Automatic Muting

This block receives a stereo serial audio stream in the standard I2S framing and turns it into pairs of 24-bit samples. It never drives the stream's clocks. A word clock, a bit clock and one data line arrive from an external source. The block oversamples all three in its own master-clock domain, which runs at 256 times the frame rate (32 kHz to 48 kHz frames).

Each channel slot may be 16, 24 or 32 bit clocks wide. The receiver measures every slot and works out the format by itself. It places the bits MSB first into a 24-bit sample: a 16-bit word is padded with zeros below, and a 32-bit slot keeps only its first 24 bits.

Once per frame the block pulses a valid strobe. With the strobe it presents both samples, a format code and a mute flag. The output is forced to silence in two cases:
- the stream has carried only zero samples for a long run of frames;
- the stream looks broken, because the slot width is unsupported or the frame period does not match the master clock.

Top module: `i2s_slave_rx`

## Requirements
- R1: While `rst` is high, every output is low: the strobe, both samples, the mute flag and the format code.
- R2: A frame with 32 bit clocks per slot reports format code 3. Each sample is the first 24 bits received in its slot, MSB first.
- R3: A frame with 24 bit clocks per slot reports format code 2. Each sample is the full 24-bit word of its slot.
- R4: A frame with 16 bit clocks per slot reports format code 1. Each sample is the 16-bit word in bits 23..8, with bits 7..0 zero.
- R5: `smp_vld_o` is high for exactly one master-clock cycle per received frame. Samples, format and mute change only in that cycle and hold in between.
- R6: The slot where the word clock is low is the left channel. Bits are taken on rising bit-clock edges. A slot's MSB is the bit at the second rising edge after the word clock changes, and its LSB is the bit at the first rising edge after the next change.
- R7: A frame whose slots are not both 16, 24 or both 32 bit clocks wide reports format code 0 with zero samples. A single such frame does not set the mute flag.
- R8: Two consecutive frames of unsupported slot width put the block into the invalid state. The mute flag rises with the second of these frames.
- R9: If the master-clock cycles between two falling word-clock edges differ from `RATIO` (256) by more than `RATE_TOL` (2), the block enters the invalid state. The mute flag rises with that frame.
- R10: The invalid state ends on the `GOOD_FRAMES`-th (4) consecutive frame that has a supported width and a good period. That frame is output unmuted.
- R11: After `ZERO_FRAMES` consecutive frames in which both samples are zero, the mute flag rises. The first frame with a non-zero sample clears it, and that frame is output unmuted.
- R12: While the mute flag is high, both output samples are zero and the strobe keeps pulsing once per frame.
- R13: Driving `pwdn_n` low clears all detection state: zero-run count, invalid state, slot tracking and period measurement. All outputs go low, and framing restarts at the next falling word-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| pwdn_n | input | 1 | Active-low power-down; clears all state while low |
| ws_i | input | 1 | Word clock from the stream source (low = left) |
| bck_i | input | 1 | Bit clock from the stream source |
| sd_i | input | 1 | Serial data, MSB first |
| smp_vld_o | output | 1 | One-cycle strobe per received frame |
| left_o | output | 24 | Left sample, left-justified |
| right_o | output | 24 | Right sample, left-justified |
| mute_o | output | 1 | High while output is forced to silence |
| fmt_o | output | 2 | Slot format: 0 unsupported, 1 = 16, 2 = 24, 3 = 32 bit clocks |

## Verification
The bench drives all three framings with bit-clock periods that vary within a frame. This catches a receiver that counts master clocks instead of bit-clock edges, or that is off by one at the slot boundary; either error shifts every word by a bit or swaps an LSB across channels. It then sends one unsupported frame, a pair of unsupported frames, and a frame stretched by eight master clocks. A design that mutes too early, too late, or on a single bad frame shows the wrong mute flag on a specific strobe. Zero runs one frame short of the threshold and at the threshold, followed by a non-zero frame, show whether the zero counter is off by one or is slow to release. A power-down in the middle of a muted run shows whether stale state survives.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SHIFT_W  = 32;
    localparam int SLOT_CW  = 6;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_16   = 2'd1,
        FMT_24   = 2'd2,
        FMT_32   = 2'd3
    } slot_fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        slot_fmt_e           fmt;
    } frame_t;

    function automatic slot_fmt_e width_to_fmt(logic [SLOT_CW-1:0] w);
        case (w)
            6'd16:   return FMT_16;
            6'd24:   return FMT_24;
            6'd32:   return FMT_32;
            default: return FMT_NONE;
        endcase
    endfunction

    // Place a received slot MSB-first into the 24-bit sample.
    function automatic logic [SAMPLE_W-1:0] justify(logic [SHIFT_W-1:0] sh, slot_fmt_e f);
        case (f)
            FMT_16:  return {sh[15:0], 8'h00};
            FMT_24:  return sh[23:0];
            FMT_32:  return sh[31:8];
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_front.sv
module i2s_rx_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic ws_raw,
    input  logic bck_raw,
    input  logic sd_raw,
    output logic ws_s,
    output logic sd_s,
    output logic bck_rise,
    output logic ws_fall
);
    localparam int LANES = 3;
    // lane 0 = word clock (idles high), lane 1 = bit clock, lane 2 = data
    localparam logic [LANES-1:0] RST_VAL = 3'b001;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             bck_q;
    logic             ws_q;

    assign raw = {sd_raw, bck_raw, ws_raw};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (clr) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            bck_q <= 1'b0;
            ws_q  <= 1'b1;
        end else begin
            bck_q <= synced[1];
            ws_q  <= synced[0];
        end
    end

    assign ws_s     = synced[0];
    assign sd_s     = synced[2];
    assign bck_rise = synced[1] & ~bck_q;
    assign ws_fall  = ws_q & ~synced[0];

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   bck_rise,
    input  logic   ws_s,
    input  logic   sd_s,
    output logic   frame_v,
    output frame_t frame_q,
    output logic   width_bad
);
    logic                ws_last;
    logic                seen;
    logic [SLOT_CW-1:0]  cnt;
    logic [SHIFT_W-1:0]  sh;
    logic [SAMPLE_W-1:0] lhold;
    slot_fmt_e           lfmt;

    logic [SHIFT_W-1:0]  nsh;
    logic [SLOT_CW-1:0]  w;
    slot_fmt_e           wfmt;
    logic [SAMPLE_W-1:0] wdata;
    logic                wb_n;

    always_comb begin
        nsh   = {sh[SHIFT_W-2:0], sd_s};
        w     = (cnt == '1) ? cnt : cnt + 1'b1;
        wfmt  = width_to_fmt(w);
        wdata = justify(nsh, wfmt);
        wb_n  = (lfmt == FMT_NONE) || (wfmt == FMT_NONE) || (lfmt != wfmt);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ws_last   <= 1'b1;
            seen      <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            lhold     <= '0;
            lfmt      <= FMT_NONE;
            frame_v   <= 1'b0;
            frame_q   <= '0;
            width_bad <= 1'b0;
        end else begin
            frame_v <= 1'b0;
            if (bck_rise) begin
                if (ws_s != ws_last) begin
                    // this edge carries the LSB of the slot that just ended
                    ws_last <= ws_s;
                    cnt     <= '0;
                    sh      <= '0;
                    if (!ws_s) seen <= 1'b1;
                    if (seen) begin
                        if (!ws_last) begin
                            lhold <= wdata;
                            lfmt  <= wfmt;
                        end else begin
                            frame_v       <= 1'b1;
                            width_bad     <= wb_n;
                            frame_q.fmt   <= wb_n ? FMT_NONE : wfmt;
                            frame_q.left  <= wb_n ? '0 : lhold;
                            frame_q.right <= wb_n ? '0 : wdata;
                        end
                    end
                end else begin
                    cnt <= w;
                    sh  <= nsh;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_rx_rate.sv
module i2s_rx_rate #(
    parameter int RATIO    = 256,
    parameter int RATE_TOL = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic ws_fall,
    output logic rate_ok
);
    localparam int CYC_W = $clog2(RATIO + RATE_TOL + 2) + 1;
    localparam int PER_W = CYC_W + 1;
    localparam logic [PER_W-1:0] PER_LO = PER_W'(RATIO - RATE_TOL);
    localparam logic [PER_W-1:0] PER_HI = PER_W'(RATIO + RATE_TOL);

    logic [CYC_W-1:0] cyc;
    logic             have;
    logic [PER_W-1:0] per;

    assign per = {1'b0, cyc} + 1'b1;

    always_ff @(posedge clk) begin
        if (clr) begin
            cyc     <= '0;
            have    <= 1'b0;
            rate_ok <= 1'b1;
        end else if (ws_fall) begin
            cyc  <= '0;
            have <= 1'b1;
            if (have) rate_ok <= (per >= PER_LO) && (per <= PER_HI);
        end else if (cyc != '1) begin
            cyc <= cyc + 1'b1;
        end
    end

endmodule

// File: rtl/i2s_rx_mute.sv
module i2s_rx_mute
    import i2s_rx_pkg::*;
#(
    parameter int ZERO_FRAMES = 2048,
    parameter int GOOD_FRAMES = 4
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                frame_v,
    input  frame_t              frame_q,
    input  logic                width_bad,
    input  logic                rate_ok,
    output logic                smp_vld_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                mute_o,
    output logic [1:0]          fmt_o
);
    localparam int ZC_W  = $clog2(ZERO_FRAMES + 1);
    localparam int RUN_W = $clog2(GOOD_FRAMES + 1);
    localparam logic [ZC_W-1:0]  ZC_MAX  = ZC_W'(ZERO_FRAMES);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_FRAMES);

    logic [ZC_W-1:0]  zcnt, zc_n;
    logic [RUN_W-1:0] run, run_n;
    logic             inval, inv_n;
    logic             prev_wb;
    logic             good, mute_n;
    logic             live_q;

    always_comb begin
        if (frame_q.left == '0 && frame_q.right == '0)
            zc_n = (zcnt == ZC_MAX) ? zcnt : zcnt + 1'b1;
        else
            zc_n = '0;
        good  = !width_bad && rate_ok;
        run_n = good ? ((run == RUN_MAX) ? run : run + 1'b1) : '0;
        if (!rate_ok || (width_bad && prev_wb)) inv_n = 1'b1;
        else if (good && run_n == RUN_MAX)      inv_n = 1'b0;
        else                                    inv_n = inval;
        mute_n = (zc_n == ZC_MAX) || inv_n;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            zcnt      <= '0;
            run       <= '0;
            inval     <= 1'b0;
            prev_wb   <= 1'b0;
            smp_vld_o <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            mute_o    <= 1'b0;
            fmt_o     <= '0;
            live_q    <= 1'b0;
        end else begin
            live_q    <= 1'b1;
            smp_vld_o <= frame_v;
            if (frame_v) begin
                zcnt    <= zc_n;
                run     <= run_n;
                inval   <= inv_n;
                prev_wb <= width_bad;
                mute_o  <= mute_n;
                fmt_o   <= frame_q.fmt;
                left_o  <= mute_n ? '0 : frame_q.left;
                right_o <= mute_n ? '0 : frame_q.right;
            end
        end
    end

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (clr)
        smp_vld_o |=> !smp_vld_o);

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (clr)
        (live_q && !smp_vld_o) |-> ($stable(left_o) && $stable(right_o)
                                    && $stable(mute_o) && $stable(fmt_o)));

    assert_muted_silent_R12: assert property (@(posedge clk) disable iff (clr)
        (smp_vld_o && mute_o) |-> (left_o == '0 && right_o == '0));

    assert_badfmt_zero_R7: assert property (@(posedge clk) disable iff (clr)
        (smp_vld_o && fmt_o == FMT_NONE) |-> (left_o == '0 && right_o == '0));

    assert_rate_mutes_R9: assert property (@(posedge clk) disable iff (clr)
        (frame_v && !rate_ok) |=> (smp_vld_o && mute_o));

    assert_nonzero_unmuted_R11: assert property (@(posedge clk) disable iff (clr)
        (smp_vld_o && (left_o != '0 || right_o != '0)) |-> !mute_o);

endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
    import i2s_rx_pkg::*;
#(
    parameter int RATIO       = 256,
    parameter int RATE_TOL    = 2,
    parameter int ZERO_FRAMES = 2048,
    parameter int GOOD_FRAMES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwdn_n,
    input  logic                ws_i,
    input  logic                bck_i,
    input  logic                sd_i,
    output logic                smp_vld_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                mute_o,
    output logic [1:0]          fmt_o
);
    logic   clr;
    logic   ws_s, sd_s, bck_rise, ws_fall;
    logic   frame_v, width_bad, rate_ok;
    frame_t frame_q;

    assign clr = rst | ~pwdn_n;

    i2s_rx_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .clr      (clr),
        .ws_raw   (ws_i),
        .bck_raw  (bck_i),
        .sd_raw   (sd_i),
        .ws_s     (ws_s),
        .sd_s     (sd_s),
        .bck_rise (bck_rise),
        .ws_fall  (ws_fall)
    );

    i2s_rx_deser u_deser (
        .clk       (clk),
        .clr       (clr),
        .bck_rise  (bck_rise),
        .ws_s      (ws_s),
        .sd_s      (sd_s),
        .frame_v   (frame_v),
        .frame_q   (frame_q),
        .width_bad (width_bad)
    );

    i2s_rx_rate #(.RATIO(RATIO), .RATE_TOL(RATE_TOL)) u_rate (
        .clk     (clk),
        .clr     (clr),
        .ws_fall (ws_fall),
        .rate_ok (rate_ok)
    );

    i2s_rx_mute #(.ZERO_FRAMES(ZERO_FRAMES), .GOOD_FRAMES(GOOD_FRAMES)) u_mute (
        .clk       (clk),
        .clr       (clr),
        .frame_v   (frame_v),
        .frame_q   (frame_q),
        .width_bad (width_bad),
        .rate_ok   (rate_ok),
        .smp_vld_o (smp_vld_o),
        .left_o    (left_o),
        .right_o   (right_o),
        .mute_o    (mute_o),
        .fmt_o     (fmt_o)
    );

endmodule

// File: tb/i2s_slave_rx_test.sv
module i2s_slave_rx_test;
    localparam int ZF    = 6;
    localparam int GF    = 4;
    localparam int RATIO = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwdn_n = 1'b1;
    logic ws_r = 1'b1, bck_r = 1'b0, sd_r = 1'b0;
    logic        vld, mute;
    logic [23:0] left, right;
    logic [1:0]  fmt;

    i2s_slave_rx #(.ZERO_FRAMES(ZF), .GOOD_FRAMES(GF)) uut (
        .clk(clk), .rst(rst), .pwdn_n(pwdn_n),
        .ws_i(ws_r), .bck_i(bck_r), .sd_i(sd_r),
        .smp_vld_o(vld), .left_o(left), .right_o(right),
        .mute_o(mute), .fmt_o(fmt)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [23:0] l;
        logic [23:0] r;
        logic        m;
        logic [1:0]  f;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_cmp = 0, n_bad = 0;
    int    m_zc = 0, m_run = 0;
    bit    m_inv = 0, m_pwb = 0;
    logic  pend = 1'b0;
    exp_t  last = '0;
    bit    done = 0;

    function automatic logic [23:0] dec(int w, logic [31:0] word);
        case (w)
            16:      return {word[15:0], 8'h00};
            24:      return word[23:0];
            32:      return word[31:8];
            default: return 24'h0;
        endcase
    endfunction

    function automatic void model_reset();
        m_zc = 0; m_run = 0; m_inv = 0; m_pwb = 0;
    endfunction

    function automatic void model_frame(int w, logic [31:0] lw, logic [31:0] rw,
                                        int total, string tag);
        int f; bit wb, rb, good; logic [23:0] dl, dr; exp_t e;
        f  = (w == 16) ? 1 : (w == 24) ? 2 : (w == 32) ? 3 : 0;
        wb = (f == 0);
        dl = dec(w, lw);
        dr = dec(w, rw);
        rb = (total < RATIO - 2) || (total > RATIO + 2);
        good = !wb && !rb;
        if (dl == 0 && dr == 0) m_zc = (m_zc < ZF) ? m_zc + 1 : m_zc;
        else                    m_zc = 0;
        m_run = good ? ((m_run < GF) ? m_run + 1 : GF) : 0;
        if (rb || (wb && m_pwb))       m_inv = 1;
        else if (good && m_run >= GF)  m_inv = 0;
        m_pwb = wb;
        e.m = (m_zc >= ZF) || m_inv;
        e.l = e.m ? 24'h0 : dl;
        e.r = e.m ? 24'h0 : dr;
        e.f = f[1:0];
        expq.push_back(e);
        tagq.push_back(tag);
    endfunction

    // One frame: left slot then right slot, data delayed one bit period
    // behind the word clock; bit periods spread over RATIO+extra cycles.
    task automatic drive_frame(int w, logic [31:0] lw, logic [31:0] rw,
                               int extra, bit push, string tag);
        int total, nb, base, ext, per, lo;
        logic b;
        total = RATIO + extra;
        nb    = 2 * w;
        base  = total / nb;
        ext   = total % nb;
        if (push) model_frame(w, lw, rw, total, tag);
        for (int k = 0; k < nb; k++) begin
            b     = (k < w) ? lw[w-1-k] : rw[w-1-(k-w)];
            per   = base + ((k < ext) ? 1 : 0);
            lo    = per / 2;
            ws_r  = (k >= w);
            sd_r  = pend;
            bck_r = 1'b0;
            pend  = b;
            repeat (lo) @(posedge clk);
            #1 bck_r = 1'b1;
            repeat (per - lo) @(posedge clk);
            #1;
        end
    endtask

    task automatic idle(int n);
        bck_r = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_empty(string tag);
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL %s: pending frames actual=%0d expected=0", tag, expq.size());
        end
    endtask

    task automatic check_quiet(string tag);
        @(negedge clk);
        n_cmp++;
        if ({vld, left, right, mute, fmt} !== 52'h0) begin
            n_bad++;
            $display("FAIL %s: outputs actual=%h expected=0", tag,
                     {vld, left, right, mute, fmt});
        end
    endtask

    // Per-clock comparison against the reference queue
    always @(negedge clk) begin
        exp_t  e, a;
        string t;
        if (rst || !pwdn_n) begin
            last = '0;
        end else if (!done) begin
            a = {left, right, mute, fmt};
            n_cmp++;
            if (vld) begin
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5: unexpected strobe actual=1 expected=0");
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (a !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual l=%h r=%h m=%b f=%0d expected l=%h r=%h m=%b f=%0d",
                                 t, a.l, a.r, a.m, a.f, e.l, e.r, e.m, e.f);
                    end
                end
                last = a;
            end else if (a !== last) begin
                n_bad++;
                $display("FAIL R5: changed without strobe actual=%h expected=%h", a, last);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5: watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        check_quiet("R1");
        @(posedge clk); #1 rst = 1'b0;
        idle(8);

        // R2 / R6: 32-bit slots, first 24 bits kept, left on low word clock
        drive_frame(32, 32'h80000001, 32'h00000100, 0, 1, "R6");
        for (int i = 0; i < 3; i++) drive_frame(32, $urandom | 32'h100, $urandom | 32'h100, 0, 1, "R2");
        // R3: 24-bit slots
        drive_frame(24, 32'h800001, 32'h000001, 0, 1, "R6");
        for (int i = 0; i < 3; i++) drive_frame(24, $urandom | 1, $urandom | 1, 0, 1, "R3");
        // R4: 16-bit slots
        drive_frame(16, 32'h8001, 32'h0001, 0, 1, "R4");
        for (int i = 0; i < 3; i++) drive_frame(16, $urandom | 1, $urandom | 1, 0, 1, "R4");
        // R7: one unsupported width, then good
        drive_frame(20, $urandom, $urandom, 0, 1, "R7");
        drive_frame(24, $urandom | 1, $urandom | 1, 0, 1, "R7");
        // R8: two unsupported in a row, then recovery R10
        drive_frame(20, $urandom, $urandom, 0, 1, "R8");
        drive_frame(20, $urandom, $urandom, 0, 1, "R8");
        for (int i = 0; i < 4; i++) drive_frame(24, $urandom | 1, $urandom | 1, 0, 1, "R10");
        // R9: stretched frame period, then recovery R10
        drive_frame(32, $urandom | 32'h100, $urandom | 32'h100, 8, 1, "R9");
        for (int i = 0; i < 4; i++) drive_frame(32, $urandom | 32'h100, $urandom | 32'h100, 0, 1, "R10");
        // R11: zero run to threshold, then release on non-zero
        for (int i = 0; i < ZF + 1; i++) drive_frame(24, 32'h0, 32'h0, 0, 1, "R11");
        drive_frame(24, 32'h0, 32'h5, 0, 1, "R11");
        // R12: muted zero run, strobes continue
        for (int i = 0; i < ZF + 1; i++) drive_frame(24, 32'h0, 32'h0, 0, 1, "R12");
        drive_frame(24, 32'h0, 32'h0, 0, 0, "flush");
        idle(20);
        check_empty("R5");

        // R13: power-down clears state, including the zero-mute run
        @(posedge clk); #1 pwdn_n = 1'b0;
        repeat (3) @(posedge clk);
        check_quiet("R13");
        @(posedge clk); #1 pwdn_n = 1'b1;
        model_reset();
        pend = 1'b0;
        idle(8);
        drive_frame(24, 32'h0, 32'h0, 0, 1, "R13");
        drive_frame(32, 32'hA5A5A5A5, 32'h5A5A5A5A, 0, 1, "R13");
        drive_frame(32, 32'h0, 32'h0, 0, 0, "flush");
        idle(20);
        check_empty("R13");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule